// File: doc/BRIEF.md
# Multi-mode 8-bit timer counter

This block is the counting core of a general-purpose timer. An 8-bit count register advances once for every cycle in which a one-cycle count-enable strobe is high. A 3-bit mode field chooses the counting behaviour: a free-running up counter, an up counter that clears after a compare value, a single-slope PWM counter, or a dual-slope (up then down) PWM counter. The upper limit of the count (TOP) is either fixed at 0xFF or taken from compare register A, depending on the mode.

Each counting tick that passes through a notable value produces a strobe: one for TOP, one for BOTTOM (0x00) and one for MAX (0xFF). A compare and waveform unit elsewhere uses these strobes. A sticky overflow flag is set by the event that the mode selects, and a write of one clears it. A separate strobe tells the compare unit when its buffered compare values may be copied into the active registers. Software can overwrite the count at any time, and the write takes effect on the next clock edge.

Top module: `tmr8_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the count is 0x00, the direction output is 0 (up) and the overflow flag is 0.
- R2: In mode 000 each tick adds one to the count, and 0xFF is followed by 0x00. A cycle with no tick and no write leaves the count unchanged in every mode.
- R3: In mode 010, TOP is compare A. A tick taken while the count equals compare A makes the next count 0x00. Otherwise the count goes up by one.
- R4: Mode 011 counts up with TOP 0xFF and wraps to 0x00. Mode 111 counts up with TOP equal to compare A and goes to 0x00 on the tick after TOP.
- R5: Modes 001 (TOP 0xFF) and 101 (TOP compare A) count up to TOP, then down to 0x00, then up again, and each endpoint value is held for a single tick. dir_down_o is 1 from the count just below TOP on the way down to the 0x00 reached on the way down. In modes 000, 010, 011 and 111 it is 0 from the cycle after that mode is applied.
- R6: top_o, bottom_o and max_o are high only in a cycle where tick_i is high, the mode is valid and no count write is made. Each is high exactly when the current count equals TOP, 0x00 and 0xFF respectively.
- R7: The overflow flag is set by max_o in modes 000, 010 and 011, by top_o in mode 111, and by bottom_o in modes 001 and 101. It reads 1 from the cycle after that event.
- R8: When ovf_clr_i is 1, the flag reads 0 in the next cycle, unless a set event occurs in the same cycle; in that case the flag stays 1.
- R9: cmp_load_o is always 1 in modes 000 and 010. It equals top_o in modes 001 and 101 and equals bottom_o in modes 011 and 111.
- R10: Mode codes 100 and 110 are reserved. In these modes ticks leave the count unchanged, and top_o, bottom_o, max_o and cmp_load_o stay 0.
- R11: When cnt_wr_i is 1, the next count is cnt_wdata_i, whatever the tick. In that cycle no event strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe, one cycle per count step |
| mode_i | input | 3 | Counting mode select |
| cmpa_i | input | 8 | Compare register A value, used as TOP in some modes |
| cnt_wr_i | input | 1 | Software write of the count value |
| cnt_wdata_i | input | 8 | Value loaded by a count write |
| ovf_clr_i | input | 1 | Write-one-to-clear of the overflow flag |
| cnt_o | output | 8 | Current count |
| dir_down_o | output | 1 | 1 while the dual-slope counter is descending |
| top_o | output | 1 | Tick taken at TOP |
| bottom_o | output | 1 | Tick taken at 0x00 |
| max_o | output | 1 | Tick taken at 0xFF |
| ovf_o | output | 1 | Sticky overflow flag |
| cmp_load_o | output | 1 | Buffered compare values may be loaded |

## Verification
The bound checker tests relations that hold in every cycle. Strobes appear only on tick cycles and never during a write. A write lands on the next edge. Reserved modes hold the count and stay quiet. The mode-000 increment and idle hold are checked. The flag follows its set and clear inputs with set taking priority. The direction flips only at the endpoints, and the load strobe matches bottom_o in single-slope PWM. Only the bench scenarios show the full count sequences: the TOP wrap for several compare values including 0 and 0xFF, the complete dual-slope triangle with one tick on each endpoint, and which event sets the flag in each mode. Those need the period-long arithmetic model the bench keeps.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_PLAIN = 2'd1,
    KIND_FAST  = 2'd2,
    KIND_PHASE = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    OVF_AT_MAX    = 2'd0,
    OVF_AT_TOP    = 2'd1,
    OVF_AT_BOTTOM = 2'd2,
    OVF_NEVER     = 2'd3
  } ovf_src_e;

  typedef struct packed {
    kind_e    kind;
    logic     top_is_a;
    ovf_src_e ovf_src;
  } mode_cfg_t;

  // Mode field decode: bit 2 moves TOP to compare A for the PWM kinds,
  // code 010 uses compare A without bit 2 set.
  function automatic mode_cfg_t decode_mode(input logic [2:0] code);
    mode_cfg_t c;
    c.kind     = KIND_NONE;
    c.top_is_a = 1'b0;
    c.ovf_src  = OVF_NEVER;
    case (code)
      3'b000: begin c.kind = KIND_PLAIN; c.ovf_src = OVF_AT_MAX;    end
      3'b010: begin c.kind = KIND_PLAIN; c.top_is_a = 1'b1; c.ovf_src = OVF_AT_MAX; end
      3'b011: begin c.kind = KIND_FAST;  c.ovf_src = OVF_AT_MAX;    end
      3'b111: begin c.kind = KIND_FAST;  c.top_is_a = 1'b1; c.ovf_src = OVF_AT_TOP; end
      3'b001: begin c.kind = KIND_PHASE; c.ovf_src = OVF_AT_BOTTOM; end
      3'b101: begin c.kind = KIND_PHASE; c.top_is_a = 1'b1; c.ovf_src = OVF_AT_BOTTOM; end
      default: c = c;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tmr8_mode_dec.sv
module tmr8_mode_dec
  import tmr8_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_cfg_t  cfg_o,
  output logic       valid_o
);

  always_comb begin
    cfg_o   = decode_mode(mode_i);
    valid_o = (cfg_o.kind != KIND_NONE);
  end

endmodule

// File: rtl/tmr8_step.sv
module tmr8_step
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic         dir_down_i,
  input  logic [W-1:0] top_i,
  input  kind_e        kind_i,
  output logic [W-1:0] cnt_nxt_o,
  output logic         dir_down_nxt_o,
  output logic         at_top_o,
  output logic         at_bottom_o,
  output logic         at_max_o
);

  localparam logic [W-1:0] CNT_ZERO = '0;
  localparam logic [W-1:0] CNT_MAX  = '1;
  localparam logic [W-1:0] CNT_ONE  = W'(1);

  // Single-slope advance: restart after TOP, otherwise step up with wrap.
  function automatic logic [W-1:0] slope_up(input logic [W-1:0] c, input logic [W-1:0] t);
    return (c == t) ? CNT_ZERO : c + CNT_ONE;
  endfunction

  // Dual-slope advance: reverse exactly on the endpoint counts.
  function automatic logic [W:0] slope_tri(input logic [W-1:0] c, input logic d,
                                           input logic [W-1:0] t);
    logic [W-1:0] n;
    logic         nd;
    if (!d) begin
      if (c == t) begin
        n  = (t == CNT_ZERO) ? CNT_ZERO : c - CNT_ONE;
        nd = (t != CNT_ZERO);
      end else begin
        n  = c + CNT_ONE;
        nd = 1'b0;
      end
    end else begin
      if (c == CNT_ZERO) begin
        n  = (t == CNT_ZERO) ? CNT_ZERO : CNT_ONE;
        nd = 1'b0;
      end else begin
        n  = c - CNT_ONE;
        nd = 1'b1;
      end
    end
    return {nd, n};
  endfunction

  logic [W:0] tri_nxt;

  always_comb begin
    at_top_o    = (cnt_i == top_i);
    at_bottom_o = (cnt_i == CNT_ZERO);
    at_max_o    = (cnt_i == CNT_MAX);
    tri_nxt     = slope_tri(cnt_i, dir_down_i, top_i);
    case (kind_i)
      KIND_PLAIN, KIND_FAST: begin
        cnt_nxt_o      = slope_up(cnt_i, top_i);
        dir_down_nxt_o = 1'b0;
      end
      KIND_PHASE: begin
        cnt_nxt_o      = tri_nxt[W-1:0];
        dir_down_nxt_o = tri_nxt[W];
      end
      default: begin
        cnt_nxt_o      = cnt_i;
        dir_down_nxt_o = dir_down_i;
      end
    endcase
  end

endmodule

// File: rtl/tmr8_ovf_flag.sv
module tmr8_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] cmpa_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_down_o,
  output logic         top_o,
  output logic         bottom_o,
  output logic         max_o,
  output logic         ovf_o,
  output logic         cmp_load_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  mode_cfg_t    cfg_w;
  logic         mode_ok_w;
  logic [W-1:0] top_val_w;
  logic [W-1:0] cnt_q;
  logic         dir_q;
  logic [W-1:0] cnt_nxt_w;
  logic         dir_nxt_w;
  logic         eq_top_w, eq_bot_w, eq_max_w;
  logic         adv_w;
  logic         ovf_set_w;

  tmr8_mode_dec u_dec (
    .mode_i  (mode_i),
    .cfg_o   (cfg_w),
    .valid_o (mode_ok_w)
  );

  assign top_val_w = cfg_w.top_is_a ? cmpa_i : CNT_MAX;

  tmr8_step #(.W(W)) u_step (
    .cnt_i          (cnt_q),
    .dir_down_i     (dir_q),
    .top_i          (top_val_w),
    .kind_i         (cfg_w.kind),
    .cnt_nxt_o      (cnt_nxt_w),
    .dir_down_nxt_o (dir_nxt_w),
    .at_top_o       (eq_top_w),
    .at_bottom_o    (eq_bot_w),
    .at_max_o       (eq_max_w)
  );

  // A tick advances the count only in a valid mode and never under a write.
  assign adv_w    = tick_i & mode_ok_w & ~cnt_wr_i;
  assign top_o    = adv_w & eq_top_w;
  assign bottom_o = adv_w & eq_bot_w;
  assign max_o    = adv_w & eq_max_w;

  always_comb begin
    case (cfg_w.ovf_src)
      OVF_AT_MAX:    ovf_set_w = max_o;
      OVF_AT_TOP:    ovf_set_w = top_o;
      OVF_AT_BOTTOM: ovf_set_w = bottom_o;
      default:       ovf_set_w = 1'b0;
    endcase
    case (cfg_w.kind)
      KIND_PLAIN: cmp_load_o = 1'b1;
      KIND_PHASE: cmp_load_o = top_o;
      KIND_FAST:  cmp_load_o = bottom_o;
      default:    cmp_load_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      if (cnt_wr_i) begin
        cnt_q <= cnt_wdata_i;
      end else if (adv_w) begin
        cnt_q <= cnt_nxt_w;
        dir_q <= dir_nxt_w;
      end
      if (mode_ok_w && cfg_w.kind != KIND_PHASE) dir_q <= 1'b0;
    end
  end

  tmr8_ovf_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovf_set_w),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_o)
  );

  assign cnt_o      = cnt_q;
  assign dir_down_o = dir_q;

endmodule

// File: rtl/tmr8_core_chk.sv
module tmr8_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic [2:0]   mode_i,
  input logic         cnt_wr_i,
  input logic [W-1:0] cnt_wdata_i,
  input logic         ovf_clr_i,
  input logic [W-1:0] cnt_o,
  input logic         dir_down_o,
  input logic         top_o,
  input logic         bottom_o,
  input logic         max_o,
  input logic         ovf_o,
  input logic         cmp_load_o,
  input logic         ovf_set_w
);

  logic rsvd_w, flat_w, tri_w, fast_w, any_ev_w;
  assign rsvd_w   = (mode_i == 3'b100) || (mode_i == 3'b110);
  assign flat_w   = (mode_i == 3'b000) || (mode_i == 3'b010) ||
                    (mode_i == 3'b011) || (mode_i == 3'b111);
  assign tri_w    = (mode_i == 3'b001) || (mode_i == 3'b101);
  assign fast_w   = (mode_i == 3'b011) || (mode_i == 3'b111);
  assign any_ev_w = top_o | bottom_o | max_o;

  assert_normal_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b000 && tick_i && !cnt_wr_i) |=> cnt_o == $past(cnt_o) + W'(1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr_i) |=> $stable(cnt_o));

  assert_dir_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flat_w |=> !dir_down_o);

  assert_dir_turns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_w && tick_i && !cnt_wr_i && !top_o && !bottom_o) |=> $stable(dir_down_o));

  assert_strobe_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |-> !any_ev_w);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set_w |=> ovf_o);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr_i && !ovf_set_w) |=> !ovf_o);

  assert_load_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fast_w |-> (cmp_load_o == bottom_o));

  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsvd_w && !cnt_wr_i) |=> cnt_o == $past(cnt_o));

  assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_w |-> (!any_ev_w && !cmp_load_o));

  assert_write_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_o == $past(cnt_wdata_i));

  assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |-> !any_ev_w);

endmodule

bind tmr8_core tmr8_core_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .mode_i      (mode_i),
  .cnt_wr_i    (cnt_wr_i),
  .cnt_wdata_i (cnt_wdata_i),
  .ovf_clr_i   (ovf_clr_i),
  .cnt_o       (cnt_o),
  .dir_down_o  (dir_down_o),
  .top_o       (top_o),
  .bottom_o    (bottom_o),
  .max_o       (max_o),
  .ovf_o       (ovf_o),
  .cmp_load_o  (cmp_load_o),
  .ovf_set_w   (ovf_set_w)
);

// File: tb/tmr8_core_tb.sv
`timescale 1ns/1ps
module tmr8_core_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic [7:0] cmpa_i = 8'd0;
  logic       cnt_wr_i = 1'b0;
  logic [7:0] cnt_wdata_i = 8'd0;
  logic       ovf_clr_i = 1'b0;
  logic [7:0] cnt_o;
  logic       dir_down_o, top_o, bottom_o, max_o, ovf_o, cmp_load_o;

  int checks = 0;
  int fails  = 0;

  int m_mode = 0;
  int m_cmpa = 0;
  int m_cnt  = 0;
  int m_p    = 0;
  bit m_flag = 1'b0;

  always #10 clk = ~clk;

  tmr8_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i), .cmpa_i(cmpa_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .ovf_clr_i(ovf_clr_i),
    .cnt_o(cnt_o), .dir_down_o(dir_down_o), .top_o(top_o), .bottom_o(bottom_o),
    .max_o(max_o), .ovf_o(ovf_o), .cmp_load_o(cmp_load_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int top_of(input int md, input int a);
    return (md == 2 || md == 5 || md == 7) ? a : 255;
  endfunction
  function automatic bit is_valid(input int md);  return !(md == 4 || md == 6); endfunction
  function automatic bit is_plain(input int md);  return md == 0 || md == 2;    endfunction
  function automatic bit is_phase(input int md);  return md == 1 || md == 5;    endfunction

  // One cycle: drive, check against the model, then advance the model.
  task automatic step(input bit tk, input bit clr);
    int t;
    bit v, e_top, e_bot, e_max, e_load, e_set;
    @(negedge clk);
    tick_i = tk; ovf_clr_i = clr; cnt_wr_i = 1'b0;
    #1;
    t      = top_of(m_mode, m_cmpa);
    v      = is_valid(m_mode);
    e_top  = v && tk && (m_cnt == t);
    e_bot  = v && tk && (m_cnt == 0);
    e_max  = v && tk && (m_cnt == 255);
    e_load = !v ? 1'b0 : is_plain(m_mode) ? 1'b1 : is_phase(m_mode) ? e_top : e_bot;
    e_set  = is_phase(m_mode) ? e_bot : (m_mode == 7) ? e_top : (v ? e_max : 1'b0);
    chk(cnt_o == 8'(m_cnt), "R2/R3/R4/R5/R10", "count", cnt_o, m_cnt);
    chk(top_o == e_top, "R6", "top_o", top_o, e_top);
    chk(bottom_o == e_bot, "R6", "bottom_o", bottom_o, e_bot);
    chk(max_o == e_max, "R6", "max_o", max_o, e_max);
    chk(cmp_load_o == e_load, "R9", "cmp_load_o", cmp_load_o, e_load);
    chk(ovf_o == m_flag, "R7/R8", "ovf_o", ovf_o, m_flag);
    if (is_phase(m_mode) && m_p != 0)
      chk(dir_down_o == (m_p > t), "R5", "dir_down_o", dir_down_o, (m_p > t));
    else if (v && !is_phase(m_mode))
      chk(dir_down_o == 1'b0, "R5", "dir_down_o flat", dir_down_o, 0);
    m_flag = e_set ? 1'b1 : (clr ? 1'b0 : m_flag);
    if (v && tk) begin
      if (is_phase(m_mode)) begin
        m_p   = (t == 0) ? 0 : (m_p + 1) % (2 * t);
        m_cnt = (m_p <= t) ? m_p : 2 * t - m_p;
      end else begin
        m_cnt = (m_cnt == t) ? 0 : (m_cnt + 1) % 256;
      end
    end
  endtask

  // Apply a mode with a simultaneous tick and count write (R11).
  task automatic setmode(input int md, input int a, input int start);
    @(negedge clk);
    mode_i = 3'(md); cmpa_i = 8'(a); cnt_wr_i = 1'b1; cnt_wdata_i = 8'(start);
    tick_i = 1'b1; ovf_clr_i = 1'b0;
    #1;
    chk(!(top_o | bottom_o | max_o), "R11", "strobe during write",
        int'(top_o | bottom_o | max_o), 0);
    m_mode = md; m_cmpa = a; m_cnt = start; m_p = start;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cnt_o == 8'd0, "R1", "count in reset", cnt_o, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cnt_o == 8'd0, "R1", "count after reset", cnt_o, 0);
    chk(dir_down_o == 1'b0, "R1", "dir after reset", dir_down_o, 0);
    chk(ovf_o == 1'b0, "R1", "flag after reset", ovf_o, 0);

    // R11: write lands on the next edge
    setmode(0, 0, 200);
    step(1'b0, 1'b0);
    chk(cnt_o == 8'd200, "R11", "written count", cnt_o, 200);

    // R2: free running through the wrap; R8: clear held across the set event
    setmode(0, 0, 0);
    for (int i = 0; i < 300; i++) step(1'b1, (i >= 250 && i <= 260) || i == 280);
    // R2: idle cycles hold
    for (int i = 0; i < 45; i++) step(i % 3 != 0, 1'b0);

    // R3: clear on compare A, several compare values
    foreach (m_cmpa_list[k]) begin
      setmode(2, m_cmpa_list[k], 0);
      for (int i = 0; i < 2 * m_cmpa_list[k] + 5; i++) step(1'b1, i == 0);
    end

    // R4: single-slope PWM with fixed and compare-A TOP; R7 flag source
    setmode(3, 0, 0);
    for (int i = 0; i < 260; i++) step(1'b1, i == 100);
    foreach (m_cmpa_list[k]) begin
      setmode(7, m_cmpa_list[k], 0);
      step(1'b0, 1'b1);
      for (int i = 0; i < 2 * m_cmpa_list[k] + 6; i++) step(i % 4 != 3, i == 2);
    end

    // R5: dual-slope with fixed and compare-A TOP
    setmode(1, 0, 0);
    for (int i = 0; i < 520; i++) step(1'b1, i == 10);
    foreach (m_cmpa_list[k]) begin
      if (m_cmpa_list[k] != 0) begin
        setmode(5, m_cmpa_list[k], 0);
        step(1'b0, 1'b1);
        for (int i = 0; i < 4 * m_cmpa_list[k] + 6; i++) step(1'b1, i == 3);
      end
    end

    // R10: reserved codes hold and stay quiet
    setmode(4, 0, 77);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    setmode(6, 255, 255);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int m_cmpa_list [5] = '{0, 1, 3, 9, 255};

endmodule